// File: doc/BRIEF.md
# UART Channel Sleep Controller

This block decides, for one UART channel, when the channel's core clock and baud-rate clock may be stopped and when they must run again. It watches a set of idle indications (receive line quiet, transmit path drained, receive FIFO drained, no interrupt that matters pending) and two software enable bits. When every condition has held long enough, it drops a registered clock-enable that feeds an external clock gating cell.

The controller runs on a free-running clock, so it keeps watching activity while the channel is asleep. A level change on the receive serial input, a change on any modem status input, a write into the transmit FIFO, or clearing either enable bit brings the channel back. While the channel sleeps, writes to the baud divisor are held back from the divisor registers and leave a sticky error flag behind.

Top module: `uart_sleep_ctl`

## Requirements
- R1: Sleep is entered only while both `efr_enh_en` and `ier_sleep_en` are 1; if either is 0 at a clock edge, `sleep_flag` is 0 after that edge and sleep is not re-entered while it stays 0.
- R2: Sleep is not entered unless `rx_idle` is 1.
- R3: Sleep is not entered unless both `txf_empty` and `tsr_empty` are 1.
- R4: Any bit of `irq_pend` blocks sleep entry except bit 1 (transmit holding empty) and bit 2 (receive time-out), which are ignored.
- R5: Sleep is not entered while `rxf_empty` is 0.
- R6: Sleep is entered once all entry conditions hold, with no wake event, at two consecutive clock edges; `sleep_flag` goes to 1 after the second edge and `clk_en` is 0 exactly while `sleep_flag` is 1. Reset gives `sleep_flag` 0, `clk_en` 1, `div_err` 0.
- R7: While asleep, a value of `rx_in` differing from its value at the previous edge wakes the channel after that edge.
- R8: While asleep, a change on any bit of `modem_in` since the previous edge wakes the channel after that edge.
- R9: While asleep, `txf_wr` high at an edge wakes the channel after that edge.
- R10: `div_wr_ok` follows `div_wr_req` while awake and is 0 while `sleep_flag` is 1; a divisor write alone does not wake the channel.
- R11: A `div_wr_req` seen at an edge while asleep sets `div_err`, which then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, never gated |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| efr_enh_en | input | 1 | Enhanced-feature enable bit |
| ier_sleep_en | input | 1 | Sleep enable bit |
| rx_idle | input | 1 | Receive line idle indication |
| txf_empty | input | 1 | Transmit FIFO empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| rxf_empty | input | 1 | Receive FIFO empty |
| irq_pend | input | IRQ_W | Pending interrupt sources, bit 1 THR empty, bit 2 RX time-out |
| rx_in | input | 1 | Receive serial input level (synchronous to clk) |
| modem_in | input | MDM_W | Modem status input levels |
| txf_wr | input | 1 | Transmit FIFO write strobe |
| div_wr_req | input | 1 | Divisor latch write request |
| clk_en | output | 1 | Enable for the core and baud clock gate |
| sleep_flag | output | 1 | Channel is asleep |
| div_wr_ok | output | 1 | Divisor write allowed through |
| div_err | output | 1 | Sticky: divisor write attempted while asleep |

## Verification
Entry conditions presented before edge k first show as `sleep_flag` 1 after edge k+1, while any wake stimulus presented before an edge clears `sleep_flag` and raises `clk_en` right after that same edge; `div_err` likewise moves one edge after the offending request, whereas `div_wr_ok` is combinational and is read in the same half cycle the request is driven. The bench drives inputs just after each falling edge and, at the next falling edge, compares every output against a behavioural model updated on the rising edge, so each result is sampled half a cycle after the edge it depends on. Directed checks sit at those same sampling points and count the edges above explicitly.

// File: rtl/uart_sleep_pkg.sv
package uart_sleep_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_ARMED  = 2'd1,
    ST_ASLEEP = 2'd2
  } slp_state_e;
endpackage

// File: rtl/usc_entry_qual.sv
// Combinational check of the idle conditions that permit sleep entry.
module usc_entry_qual #(
  parameter int unsigned          IRQ_W        = 6,
  parameter logic [IRQ_W-1:0]     IRQ_IGN_MASK = 6'b000110
) (
  input  logic             en_both,
  input  logic             rx_idle,
  input  logic             txf_empty,
  input  logic             tsr_empty,
  input  logic             rxf_empty,
  input  logic [IRQ_W-1:0] irq_pend,
  output logic             entry_ok
);
  logic [IRQ_W-1:0] irq_block;

  generate
    for (genvar i = 0; i < IRQ_W; i++) begin : g_irq
      if (IRQ_IGN_MASK[i]) begin : g_ign
        assign irq_block[i] = 1'b0;
      end else begin : g_use
        assign irq_block[i] = irq_pend[i];
      end
    end
  endgenerate

  always_comb begin
    entry_ok = en_both & rx_idle & txf_empty & tsr_empty & rxf_empty
             & ~(|irq_block);
  end
endmodule

// File: rtl/usc_wake_det.sv
// Activity detector on the free-running clock.
module usc_wake_det #(
  parameter int unsigned MDM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_both,
  input  logic             rx_in,
  input  logic [MDM_W-1:0] modem_in,
  input  logic             txf_wr,
  output logic             wake_evt
);
  logic             rx_q,  rx_d;
  logic [MDM_W-1:0] mdm_q, mdm_d;

  always_comb begin
    rx_d     = rx_in;
    mdm_d    = modem_in;
    wake_evt = (rx_in != rx_q) | (modem_in != mdm_q) | txf_wr | ~en_both;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= 1'b1;
      mdm_q <= '0;
    end else begin
      rx_q  <= rx_d;
      mdm_q <= mdm_d;
    end
  end
endmodule

// File: rtl/usc_div_guard.sv
// Holds back divisor writes while asleep and records attempts.
module usc_div_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic asleep,
  input  logic div_wr_req,
  output logic div_wr_ok,
  output logic div_err
);
  logic err_q, err_d, err_en;

  always_comb begin
    div_wr_ok = div_wr_req & ~asleep;
    err_en    = div_wr_req & asleep;
    err_d     = 1'b1;
    div_err   = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/uart_sleep_ctl.sv
module uart_sleep_ctl #(
  parameter int unsigned      IRQ_W        = 6,
  parameter int unsigned      MDM_W        = 4,
  parameter logic [IRQ_W-1:0] IRQ_IGN_MASK = 6'b000110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             efr_enh_en,
  input  logic             ier_sleep_en,
  input  logic             rx_idle,
  input  logic             txf_empty,
  input  logic             tsr_empty,
  input  logic             rxf_empty,
  input  logic [IRQ_W-1:0] irq_pend,
  input  logic             rx_in,
  input  logic [MDM_W-1:0] modem_in,
  input  logic             txf_wr,
  input  logic             div_wr_req,
  output logic             clk_en,
  output logic             sleep_flag,
  output logic             div_wr_ok,
  output logic             div_err
);
  import uart_sleep_pkg::*;

  logic       en_both;
  logic       entry_ok;
  logic       wake_evt;
  slp_state_e st_q, st_d;
  logic       asleep_q;

  assign en_both = efr_enh_en & ier_sleep_en;

  usc_entry_qual #(
    .IRQ_W        (IRQ_W),
    .IRQ_IGN_MASK (IRQ_IGN_MASK)
  ) u_qual (
    .en_both   (en_both),
    .rx_idle   (rx_idle),
    .txf_empty (txf_empty),
    .tsr_empty (tsr_empty),
    .rxf_empty (rxf_empty),
    .irq_pend  (irq_pend),
    .entry_ok  (entry_ok)
  );

  usc_wake_det #(
    .MDM_W (MDM_W)
  ) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_both  (en_both),
    .rx_in    (rx_in),
    .modem_in (modem_in),
    .txf_wr   (txf_wr),
    .wake_evt (wake_evt)
  );

  // Next-state: two clean edges in a row arm then enter sleep.
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_AWAKE:  if (entry_ok && !wake_evt) st_d = ST_ARMED;
      ST_ARMED:  st_d = (entry_ok && !wake_evt) ? ST_ASLEEP : ST_AWAKE;
      ST_ASLEEP: if (wake_evt) st_d = ST_AWAKE;
      default:   st_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_AWAKE;
      asleep_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      asleep_q <= (st_d == ST_ASLEEP);
    end
  end

  assign sleep_flag = asleep_q;
  assign clk_en     = ~asleep_q;

  usc_div_guard u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .asleep     (asleep_q),
    .div_wr_req (div_wr_req),
    .div_wr_ok  (div_wr_ok),
    .div_err    (div_err)
  );
endmodule

// File: rtl/uart_sleep_chk.sv
module uart_sleep_chk #(
  parameter int unsigned      IRQ_W        = 6,
  parameter int unsigned      MDM_W        = 4,
  parameter logic [IRQ_W-1:0] IRQ_IGN_MASK = 6'b000110
) (
  input logic             clk,
  input logic             rst_n,
  input logic             efr_enh_en,
  input logic             ier_sleep_en,
  input logic             rx_idle,
  input logic             txf_empty,
  input logic             tsr_empty,
  input logic             rxf_empty,
  input logic [IRQ_W-1:0] irq_pend,
  input logic             rx_in,
  input logic [MDM_W-1:0] modem_in,
  input logic             txf_wr,
  input logic             div_wr_req,
  input logic             clk_en,
  input logic             sleep_flag,
  input logic             div_wr_ok,
  input logic             div_err
);
  assert_enable_wake_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!efr_enh_en || !ier_sleep_en) |=> !sleep_flag);

  assert_rx_idle_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_flag) |-> ($past(rx_idle, 1) && $past(rx_idle, 2)));

  assert_tx_empty_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_flag) |-> ($past(txf_empty) && $past(tsr_empty)));

  assert_irq_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_flag) |-> (($past(irq_pend) & ~IRQ_IGN_MASK) == '0));

  assert_rxf_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_flag) |-> $past(rxf_empty));

  assert_clk_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_flag |-> !clk_en);

  assert_rx_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_flag && (rx_in != $past(rx_in))) |=> !sleep_flag);

  assert_modem_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_flag && (modem_in != $past(modem_in))) |=> !sleep_flag);

  assert_txwr_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_flag && txf_wr) |=> !sleep_flag);

  assert_div_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_flag |-> !div_wr_ok);

  assert_div_err_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_flag && div_wr_req) |=> div_err);

  assert_div_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |=> div_err);
endmodule

bind uart_sleep_ctl uart_sleep_chk #(
  .IRQ_W        (IRQ_W),
  .MDM_W        (MDM_W),
  .IRQ_IGN_MASK (IRQ_IGN_MASK)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .efr_enh_en   (efr_enh_en),
  .ier_sleep_en (ier_sleep_en),
  .rx_idle      (rx_idle),
  .txf_empty    (txf_empty),
  .tsr_empty    (tsr_empty),
  .rxf_empty    (rxf_empty),
  .irq_pend     (irq_pend),
  .rx_in        (rx_in),
  .modem_in     (modem_in),
  .txf_wr       (txf_wr),
  .div_wr_req   (div_wr_req),
  .clk_en       (clk_en),
  .sleep_flag   (sleep_flag),
  .div_wr_ok    (div_wr_ok),
  .div_err      (div_err)
);

// File: tb/sim_uart_sleep_ctl.sv
`timescale 1ns/1ps
module sim_uart_sleep_ctl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       efr_enh_en, ier_sleep_en;
  logic       rx_idle, txf_empty, tsr_empty, rxf_empty;
  logic [5:0] irq_pend;
  logic       rx_in;
  logic [3:0] modem_in;
  logic       txf_wr, div_wr_req;
  logic       clk_en, sleep_flag, div_wr_ok, div_err;

  int n_checks = 0;
  int n_errors = 0;

  // behavioural reference state
  int         m_run = 0;
  bit         m_sleep = 0;
  bit         m_err = 0;
  bit         m_prev_rx = 1;
  logic [3:0] m_prev_m = 4'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_sleep_ctl u0 (
    .clk(clk), .rst_n(rst_n), .efr_enh_en(efr_enh_en), .ier_sleep_en(ier_sleep_en),
    .rx_idle(rx_idle), .txf_empty(txf_empty), .tsr_empty(tsr_empty), .rxf_empty(rxf_empty),
    .irq_pend(irq_pend), .rx_in(rx_in), .modem_in(modem_in), .txf_wr(txf_wr),
    .div_wr_req(div_wr_req), .clk_en(clk_en), .sleep_flag(sleep_flag),
    .div_wr_ok(div_wr_ok), .div_err(div_err)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_sleep = 0; m_err = 0; m_prev_rx = 1; m_prev_m = 4'h0;
    end else begin
      bit evt, ok;
      evt = (rx_in != m_prev_rx) || (modem_in != m_prev_m) || txf_wr
            || !(efr_enh_en && ier_sleep_en);
      ok  = efr_enh_en && ier_sleep_en && rx_idle && txf_empty && tsr_empty
            && rxf_empty && ((irq_pend & 6'b111001) == 6'b0);
      if (div_wr_req && m_sleep) m_err = 1;
      if (m_sleep) begin
        if (evt) begin m_sleep = 0; m_run = 0; end
      end else if (ok && !evt) begin
        m_run = m_run + 1;
        if (m_run >= 2) begin m_sleep = 1; m_run = 0; end
      end else begin
        m_run = 0;
      end
      m_prev_rx = rx_in;
      m_prev_m  = modem_in;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // advance to the next falling edge and compare all outputs with the model
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R6 model sleep_flag", sleep_flag, m_sleep);
      chk("R6 model clk_en", clk_en, !m_sleep);
      chk("R10 model div_wr_ok", div_wr_ok, div_wr_req && !m_sleep);
      chk("R11 model div_err", div_err, m_err);
    end
  endtask

  task automatic all_idle();
    efr_enh_en = 1; ier_sleep_en = 1; rx_idle = 1; txf_empty = 1; tsr_empty = 1;
    rxf_empty = 1; irq_pend = 6'b0; txf_wr = 0; div_wr_req = 0;
  endtask

  task automatic wake_by_write();
    txf_wr = 1; tick(); txf_wr = 0;
    chk("R9 wake on tx write", sleep_flag, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 0;
    all_idle(); efr_enh_en = 0; ier_sleep_en = 0; rx_in = 1; modem_in = 4'h0;
    tick(3);
    chk("R6 reset sleep_flag", sleep_flag, 1'b0);
    chk("R6 reset clk_en", clk_en, 1'b1);
    chk("R11 reset div_err", div_err, 1'b0);
    rst_n = 1;
    all_idle();
    tick();
    chk("R6 not asleep after one edge", sleep_flag, 1'b0);
    tick();
    chk("R6 asleep after two edges", sleep_flag, 1'b1);
    chk("R6 clock stopped", clk_en, 1'b0);

    div_wr_req = 1; #1;
    chk("R10 divisor write blocked", div_wr_ok, 1'b0);
    tick(); div_wr_req = 0;
    chk("R11 error set", div_err, 1'b1);
    chk("R10 divisor write does not wake", sleep_flag, 1'b1);

    rx_in = 0; tick();
    chk("R7 wake on rx edge", sleep_flag, 1'b0);
    rx_in = 1; tick(3);
    chk("R7 re-entry after rx settles", sleep_flag, 1'b1);
    chk("R11 error sticky", div_err, 1'b1);
    wake_by_write();
    div_wr_req = 1; #1;
    chk("R10 divisor write passes awake", div_wr_ok, 1'b1);
    tick(); div_wr_req = 0; tick();
    chk("R6 re-entered", sleep_flag, 1'b1);

    modem_in = 4'b0100; tick();
    chk("R8 wake on modem change", sleep_flag, 1'b0);
    tick(2);
    chk("R8 re-entry with new modem level", sleep_flag, 1'b1);

    wake_by_write(); tick(2);
    chk("R9 re-entry after write", sleep_flag, 1'b1);

    ier_sleep_en = 0; tick();
    chk("R1 clear sleep enable wakes", sleep_flag, 1'b0);
    tick(4);
    chk("R1 no re-entry while disabled", sleep_flag, 1'b0);
    ier_sleep_en = 1; tick(2);
    chk("R1 re-entry when enabled", sleep_flag, 1'b1);
    efr_enh_en = 0; tick();
    chk("R1 clear enhanced enable wakes", sleep_flag, 1'b0);
    tick(4);
    chk("R1 blocked by enhanced enable", sleep_flag, 1'b0);
    efr_enh_en = 1; tick(2);

    wake_by_write(); rx_idle = 0; tick(4);
    chk("R2 rx not idle blocks", sleep_flag, 1'b0);
    rx_idle = 1; txf_empty = 0; tick(4);
    chk("R3 tx fifo not empty blocks", sleep_flag, 1'b0);
    txf_empty = 1; tsr_empty = 0; tick(4);
    chk("R3 shift register busy blocks", sleep_flag, 1'b0);
    tsr_empty = 1; rxf_empty = 0; tick(4);
    chk("R5 rx fifo data blocks", sleep_flag, 1'b0);
    rxf_empty = 1; irq_pend = 6'b000001; tick(4);
    chk("R4 irq bit 0 blocks", sleep_flag, 1'b0);
    irq_pend = 6'b100000; tick(4);
    chk("R4 irq bit 5 blocks", sleep_flag, 1'b0);
    irq_pend = 6'b000110; tick(2);
    chk("R4 thr and timeout ignored", sleep_flag, 1'b1);

    wake_by_write(); irq_pend = 6'b0; rx_idle = 0; tick();
    rx_idle = 1; tick(); rx_idle = 0; tick();
    chk("R6 single good edge not enough", sleep_flag, 1'b0);
    tick(2);
    chk("R6 still awake", sleep_flag, 1'b0);
    rx_idle = 1; tick();
    txf_wr = 1; tick(); txf_wr = 0;
    chk("R6 event restarts qualification", sleep_flag, 1'b0);
    tick();
    chk("R6 one edge after restart", sleep_flag, 1'b0);
    tick();
    chk("R6 asleep after restart", sleep_flag, 1'b1);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule